// File: doc/BRIEF.md
# Bridge Queue Space Gate

This block decides, for both sides of a bridge, whether the posted write queue must be reported as full and whether a memory read may be launched into the read data queue. Each side supplies its current free space in DWORDs for both queues and the command of the pending read. A shared cache line size and a small control field complete the inputs. The posted write decision raises `*_post_full`, which the surrounding logic turns into a retry to incoming posted writes. The read decision raises `*_read_go` when enough room is free for the pending read.

The thresholds are not fixed almost-full levels. They scale with the programmed cache line size. For reads they also depend on the kind of command: a plain read, a read line or a read multiple. Both outputs are combinational functions of the present inputs, so a new free count is reflected in the same cycle. The queue storage is outside this block.

Top module: `bridge_space_gate`

## Requirements
- R1: A cache line size input of zero is used as 8 DWORDs in every comparison on both sides. Any non-zero value is used unchanged.
- R2: With the side's posted write threshold bit at 0, `post_full` is 1 exactly when the free posted write space is below one cache line.
- R3: With the posted write threshold bit at 1, `post_full` is 1 exactly when the free space is below floor(cache line / 2). For odd line sizes this rounds the half down.
- R4: With read threshold code 0, `read_go` is 1 for any read command exactly when at least 8 DWORDs are free in the read data queue.
- R5: Read threshold code 1 gives the same `read_go` as code 0 for every input.
- R6: With read threshold code 2, read line (cmd 1) and read multiple (cmd 2) need at least one free cache line. Plain memory read (cmd 0) needs at least 8 free DWORDs.
- R7: With read threshold code 3, every read command needs at least one free cache line. This holds even when the line is smaller than 8 DWORDs.
- R8: Command code 3 means no read is pending, and `read_go` is then 0 whatever the free space.
- R9: Control field layout: bit 0 is the primary posted write threshold and bit 1 the secondary one. Bits [3:2] are the primary read threshold code and bits [5:4] the secondary code. Each side uses only its own fields and its own free counts.
- R10: Both outputs follow the inputs combinationally, in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_fields | input | 6 | Threshold fields for both sides (layout in R9) |
| line_dw | input | LINE_W | Cache line size in DWORDs, 0 read as 8 |
| pri_pw_free | input | FREE_W | Primary posted write queue free DWORDs |
| pri_rd_free | input | FREE_W | Primary read data queue free DWORDs |
| pri_rd_cmd | input | 2 | Primary pending read: 0 plain, 1 line, 2 multiple, 3 none |
| sec_pw_free | input | FREE_W | Secondary posted write queue free DWORDs |
| sec_rd_free | input | FREE_W | Secondary read data queue free DWORDs |
| sec_rd_cmd | input | 2 | Secondary pending read, same encoding |
| pri_post_full | output | 1 | Primary posted write queue counts as full |
| pri_read_go | output | 1 | Primary read may start |
| sec_post_full | output | 1 | Secondary posted write queue counts as full |
| sec_read_go | output | 1 | Secondary read may start |

## Verification
The hardest cases sit exactly one DWORD on either side of a threshold, and random free counts seldom land there. The stimulus therefore draws each free count as the active threshold plus a small offset from -2 to +2. It mixes in line sizes of 0 and odd values and line sizes below 8, so that under code 3 a read starts with fewer than 8 DWORDs free. Each cycle the two sides get different threshold codes, which shows any crossing of fields between sides.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic [1:0] {
    RD_PLAIN = 2'd0,
    RD_LINE  = 2'd1,
    RD_MULT  = 2'd2,
    RD_NONE  = 2'd3
  } rd_cmd_e;

  localparam int unsigned MIN_READ_DW  = 8;
  localparam int unsigned ZERO_LINE_DW = 8;
  localparam int unsigned SIDES        = 2;

  // Code 1 is not a legal setting; it folds onto code 0.
  function automatic logic [1:0] fold_rd_thr(input logic [1:0] code);
    return (code == 2'd1) ? 2'd0 : code;
  endfunction

  // Space that must be free before the posted write queue stops being full.
  function automatic logic [31:0] post_need(input logic [31:0] line, input logic half);
    return half ? (line >> 1) : line;
  endfunction

  // Space that must be free before a read may launch.
  function automatic logic [31:0] read_need(input logic [31:0] line,
                                            input logic [1:0]  thr,
                                            input rd_cmd_e     cmd);
    logic wants_line;
    wants_line = (thr == 2'd3) || ((thr == 2'd2) && (cmd != RD_PLAIN));
    return wants_line ? line : 32'(MIN_READ_DW);
  endfunction

endpackage

// File: rtl/bsg_line_norm.sv
module bsg_line_norm #(
  parameter int unsigned LINE_W = 8
) (
  input  logic [LINE_W-1:0] line_raw,
  output logic [LINE_W-1:0] line_eff
);
  import bsg_pkg::*;

  logic line_is_zero;
  assign line_is_zero = (line_raw == '0);
  assign line_eff     = line_is_zero ? LINE_W'(ZERO_LINE_DW) : line_raw;

  always_comb begin
    if (!$isunknown(line_raw)) begin
      // R1
      line_nonzero_chk: assert (line_eff != '0);
      // R1
      line_pass_chk: assert (line_is_zero || (line_eff == line_raw));
    end
  end
endmodule

// File: rtl/bsg_post_gate.sv
module bsg_post_gate #(
  parameter int unsigned FREE_W = 10,
  parameter int unsigned LINE_W = 8
) (
  input  logic [FREE_W-1:0] free_dw,
  input  logic [LINE_W-1:0] line_eff,
  input  logic              half_thr,
  output logic              post_full
);
  import bsg_pkg::*;

  logic [31:0] free_ext;
  logic [31:0] line_ext;
  logic [31:0] need_dw;

  assign free_ext  = 32'(free_dw);
  assign line_ext  = 32'(line_eff);
  assign need_dw   = post_need(line_ext, half_thr);
  assign post_full = (free_ext < need_dw);

  always_comb begin
    if (!$isunknown({free_dw, line_eff, half_thr})) begin
      // R2
      full_below_line_chk: assert (!post_full || (free_ext < line_ext));
      // R2
      empty_full_chk: assert (half_thr || (free_dw != '0) || post_full);
    end
  end
endmodule

// File: rtl/bsg_read_gate.sv
module bsg_read_gate #(
  parameter int unsigned FREE_W = 10,
  parameter int unsigned LINE_W = 8
) (
  input  logic [FREE_W-1:0] free_dw,
  input  logic [LINE_W-1:0] line_eff,
  input  logic [1:0]        thr_code,
  input  logic [1:0]        cmd_code,
  output logic              read_go
);
  import bsg_pkg::*;

  rd_cmd_e     cmd;
  logic [1:0]  thr_fold;
  logic        is_read;
  logic [31:0] free_ext;
  logic [31:0] line_ext;
  logic [31:0] need_dw;

  assign cmd      = rd_cmd_e'(cmd_code);
  assign thr_fold = fold_rd_thr(thr_code);
  assign is_read  = (cmd != RD_NONE);
  assign free_ext = 32'(free_dw);
  assign line_ext = 32'(line_eff);
  assign need_dw  = read_need(line_ext, thr_fold, cmd);
  assign read_go  = is_read && (free_ext >= need_dw);

  always_comb begin
    if (!$isunknown({free_dw, line_eff, thr_code, cmd_code})) begin
      // R8
      idle_no_go_chk: assert (!((cmd_code == 2'd3) && read_go));
      // R4
      go_has_room_chk: assert (!read_go || (free_ext >= 32'(MIN_READ_DW)) || (free_ext >= line_ext));
      // R6
      ample_room_go_chk: assert (!(is_read && (free_ext >= 32'(MIN_READ_DW)) && (free_ext >= line_ext)) || read_go);
    end
  end
endmodule

// File: rtl/bsg_side.sv
module bsg_side #(
  parameter int unsigned FREE_W = 10,
  parameter int unsigned LINE_W = 8
) (
  input  logic [LINE_W-1:0] line_eff,
  input  logic              pw_half,
  input  logic [1:0]        rd_thr,
  input  logic [FREE_W-1:0] pw_free,
  input  logic [FREE_W-1:0] rd_free,
  input  logic [1:0]        rd_cmd,
  output logic              post_full,
  output logic              read_go
);
  bsg_post_gate #(.FREE_W(FREE_W), .LINE_W(LINE_W)) u_post (
    .free_dw  (pw_free),
    .line_eff (line_eff),
    .half_thr (pw_half),
    .post_full(post_full)
  );

  bsg_read_gate #(.FREE_W(FREE_W), .LINE_W(LINE_W)) u_read (
    .free_dw (rd_free),
    .line_eff(line_eff),
    .thr_code(rd_thr),
    .cmd_code(rd_cmd),
    .read_go (read_go)
  );
endmodule

// File: rtl/bridge_space_gate.sv
module bridge_space_gate #(
  parameter int unsigned FREE_W = 10,
  parameter int unsigned LINE_W = 8
) (
  input  logic [5:0]        ctrl_fields,
  input  logic [LINE_W-1:0] line_dw,
  input  logic [FREE_W-1:0] pri_pw_free,
  input  logic [FREE_W-1:0] pri_rd_free,
  input  logic [1:0]        pri_rd_cmd,
  input  logic [FREE_W-1:0] sec_pw_free,
  input  logic [FREE_W-1:0] sec_rd_free,
  input  logic [1:0]        sec_rd_cmd,
  output logic              pri_post_full,
  output logic              pri_read_go,
  output logic              sec_post_full,
  output logic              sec_read_go
);
  import bsg_pkg::*;

  localparam int unsigned PW_BIT0   = 0;
  localparam int unsigned RD_LSB0   = 2;
  localparam int unsigned RD_FIELDW = 2;

  logic [LINE_W-1:0] line_eff;
  logic [FREE_W-1:0] pw_free_a [SIDES];
  logic [FREE_W-1:0] rd_free_a [SIDES];
  logic [1:0]        rd_cmd_a  [SIDES];
  logic              full_a    [SIDES];
  logic              go_a      [SIDES];

  bsg_line_norm #(.LINE_W(LINE_W)) u_norm (
    .line_raw(line_dw),
    .line_eff(line_eff)
  );

  assign pw_free_a[0] = pri_pw_free;
  assign pw_free_a[1] = sec_pw_free;
  assign rd_free_a[0] = pri_rd_free;
  assign rd_free_a[1] = sec_rd_free;
  assign rd_cmd_a[0]  = pri_rd_cmd;
  assign rd_cmd_a[1]  = sec_rd_cmd;

  // R9: side s takes bit PW_BIT0+s and field RD_LSB0+2*s
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    bsg_side #(.FREE_W(FREE_W), .LINE_W(LINE_W)) u_side (
      .line_eff (line_eff),
      .pw_half  (ctrl_fields[PW_BIT0 + s]),
      .rd_thr   (ctrl_fields[RD_LSB0 + RD_FIELDW*s +: RD_FIELDW]),
      .pw_free  (pw_free_a[s]),
      .rd_free  (rd_free_a[s]),
      .rd_cmd   (rd_cmd_a[s]),
      .post_full(full_a[s]),
      .read_go  (go_a[s])
    );
  end

  assign pri_post_full = full_a[0];
  assign sec_post_full = full_a[1];
  assign pri_read_go   = go_a[0];
  assign sec_read_go   = go_a[1];

  always_comb begin
    if (!$isunknown({ctrl_fields, line_dw, pri_pw_free, sec_pw_free})) begin
      // R9
      same_inputs_same_full_chk: assert (!((ctrl_fields[0] == ctrl_fields[1]) &&
                                          (pri_pw_free == sec_pw_free)) ||
                                         (pri_post_full == sec_post_full));
    end
  end
endmodule

// File: tb/bridge_space_gate_bench.sv
module bridge_space_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FREE_W = 10;
  localparam int LINE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]        ctrl_fields = '0;
  logic [LINE_W-1:0] line_dw = '0;
  logic [FREE_W-1:0] pri_pw_free = '0, pri_rd_free = '0, sec_pw_free = '0, sec_rd_free = '0;
  logic [1:0]        pri_rd_cmd = '0, sec_rd_cmd = '0;
  logic pri_post_full, pri_read_go, sec_post_full, sec_read_go;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_space_gate #(.FREE_W(FREE_W), .LINE_W(LINE_W)) u_bridge_space_gate (
    .ctrl_fields(ctrl_fields), .line_dw(line_dw),
    .pri_pw_free(pri_pw_free), .pri_rd_free(pri_rd_free), .pri_rd_cmd(pri_rd_cmd),
    .sec_pw_free(sec_pw_free), .sec_rd_free(sec_rd_free), .sec_rd_cmd(sec_rd_cmd),
    .pri_post_full(pri_post_full), .pri_read_go(pri_read_go),
    .sec_post_full(sec_post_full), .sec_read_go(sec_read_go)
  );

  // Reference model written from the requirements.
  function automatic int eff_line(int raw);
    if (raw == 0) return 8;
    return raw;
  endfunction

  function automatic bit model_full(int raw, int free, int half);
    int room;
    room = (half != 0) ? eff_line(raw) / 2 : eff_line(raw);
    return free < room;
  endfunction

  function automatic bit model_go(int raw, int free, int thr, int cmd);
    int room;
    if (cmd == 3) return 1'b0;
    room = 8;
    if (thr == 3) room = eff_line(raw);
    if (thr == 2 && (cmd == 1 || cmd == 2)) room = eff_line(raw);
    return free >= room;
  endfunction

  function automatic string full_tag(int raw, int half);
    if (raw == 0) return "R1";
    return (half != 0) ? "R3" : "R2";
  endfunction

  function automatic string go_tag(int thr, int cmd);
    if (cmd == 3) return "R8";
    case (thr)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Compare all four outputs against the model; extra tag names the phase.
  task automatic check_all(input string extra);
    int raw = int'(line_dw);
    int pp = int'(ctrl_fields[0]);
    int sp = int'(ctrl_fields[1]);
    int pr = int'(ctrl_fields[3:2]);
    int sr = int'(ctrl_fields[5:4]);
    cmp({extra, full_tag(raw, pp), " R10"}, "pri_post_full", pri_post_full,
        model_full(raw, int'(pri_pw_free), pp));
    cmp({extra, full_tag(raw, sp), " R10"}, "sec_post_full", sec_post_full,
        model_full(raw, int'(sec_pw_free), sp));
    cmp({extra, go_tag(pr, int'(pri_rd_cmd))}, "pri_read_go", pri_read_go,
        model_go(raw, int'(pri_rd_free), pr, int'(pri_rd_cmd)));
    cmp({extra, go_tag(sr, int'(sec_rd_cmd))}, "sec_read_go", sec_read_go,
        model_go(raw, int'(sec_rd_free), sr, int'(sec_rd_cmd)));
  endtask

  task automatic apply(input int ctl, input int line, input int ppw, input int prd, input int pcmd,
                       input int spw, input int srd, input int scmd, input string extra);
    @(posedge clk);
    ctrl_fields = 6'(ctl);
    line_dw     = LINE_W'(line);
    pri_pw_free = FREE_W'(ppw);
    pri_rd_free = FREE_W'(prd);
    pri_rd_cmd  = 2'(pcmd);
    sec_pw_free = FREE_W'(spw);
    sec_rd_free = FREE_W'(srd);
    sec_rd_cmd  = 2'(scmd);
    @(negedge clk);
    check_all(extra);
  endtask

  function automatic int near(int base, int maxv);
    int v = base + int'($urandom_range(4)) - 2;
    if (v < 0) v = 0;
    if (v > maxv) v = maxv;
    return v;
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: all zero inputs, line read as 8 (R1)
    @(negedge clk);
    cmp("R1", "idle pri_post_full", pri_post_full, 1'b1);
    cmp("R1", "idle pri_read_go", pri_read_go, 1'b0);
    cmp("R1", "idle sec_post_full", sec_post_full, 1'b1);
    cmp("R1", "idle sec_read_go", sec_read_go, 1'b0);
    // R2 edges of one cache line
    apply(6'b000000, 16, 15, 0, 3, 16, 0, 3, "R2 ");
    // R3 half line, odd line rounds down
    apply(6'b000011, 16, 7, 0, 3, 8, 0, 3, "R3 ");
    apply(6'b000011, 9, 3, 0, 3, 4, 0, 3, "R3 ");
    // R1 zero line on posted side
    apply(6'b000000, 0, 7, 0, 3, 8, 0, 3, "R1 ");
    // R4 and R5: need 8 regardless of line
    apply(6'b010000, 32, 0, 8, 1, 0, 7, 2, "R4 ");
    apply(6'b010100, 32, 0, 7, 2, 0, 8, 1, "R5 ");
    // R6
    apply(6'b101000, 32, 0, 8, 0, 0, 31, 2, "R6 ");
    apply(6'b101000, 32, 0, 31, 1, 0, 32, 1, "R6 ");
    // R7 including line below 8
    apply(6'b111100, 32, 0, 31, 0, 0, 32, 0, "R7 ");
    apply(6'b111100, 4, 0, 4, 0, 0, 3, 2, "R7 ");
    // R8 idle command with huge room
    apply(6'b111100, 4, 0, 1023, 3, 0, 1023, 3, "R8 ");
    // R9 sides use own fields only
    apply(6'b001110, 32, 20, 20, 0, 20, 20, 0, "R9 ");
    apply(6'b110001, 32, 20, 20, 0, 20, 20, 0, "R9 ");
    // Randomised boundary sweep
    for (int i = 0; i < 4000; i++) begin
      int ln = ($urandom_range(3) == 0) ? 0 : int'($urandom_range(255));
      int el = eff_line(ln);
      int ctl = int'($urandom_range(63));
      int ppw = near(((ctl & 1) != 0) ? el / 2 : el, 1023);
      int spw = near(((ctl & 2) != 0) ? el / 2 : el, 1023);
      int prd = near(($urandom_range(1) == 0) ? 8 : el, 1023);
      int srd = near(($urandom_range(1) == 0) ? 8 : el, 1023);
      apply(ctl, ln, ppw, prd, int'($urandom_range(3)), spw, srd, int'($urandom_range(3)), "RND ");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule